// File: doc/BRIEF.md
# Segment Register File with Memory-Control Fault Checker

This block keeps the sixteen 32-bit segment registers of a 32-bit memory management unit. It also screens each decoded memory-control operation for the exception conditions that apply to it. Every cycle it receives one operation code together with the operating context:

- a source data word;
- an address operand;
- a 4-bit immediate register number;
- the little-endian mode flag;
- the translation-enable flag;
- the external-access enable bit.

Move-to operations update a segment register on the clock edge. Move-from operations return the selected register at once. A register is named either by the immediate or by the top nibble of the address operand.

For every other operation, the block decides whether it is accepted or faults. A fault is reported as an illegal instruction, a data storage fault or an alignment fault. The code and a 32-bit status vector are registered, so they appear in the cycle after the operation. Only the most important fault is reported, and a faulting operation writes no register.

Top module: `segchk_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all sixteen registers become zero and, after that edge, `exc_code` and `exc_status` are zero.
- R2: A direct move-to (op 1) writes `rs_data` into the register numbered by `sr_imm` at the clock edge. The new value is visible from the following cycle.
- R3: Indirect move-to (op 2) and move-from (op 4) select the register with `ea[31:28]`, which are bits 0–3 in big-endian numbering.
- R4: A direct move-from (op 3) or an indirect move-from (op 4) drives `rd_data` combinationally with the current contents of the register. Every other op drives `rd_data` to zero.
- R5: An external-control read or write (op 5 or 6) with `ext_en` = 0 yields `exc_code` = 2 (data storage) in the next cycle. `exc_status` then has only bit 20 set, which is big-endian bit 11.
- R6: With `le_mode` = 1, load or store multiple (ops 7, 8) and string load or store (ops 9, 10) yield `exc_code` = 3 (alignment).
- R7: With `xlate_en` = 1 and `ea[1:0]` not zero, the following ops yield `exc_code` = 3: floating-point load or store (ops 13, 14), multiple (ops 7, 8), reserved load (op 11), conditional store (op 12) and external control (ops 5, 6).
- R8: TLB invalidate all (op 16) yields `exc_code` = 1 (illegal). TLB invalidate entry (op 15) yields no exception.
- R9: When several conditions hold, only the highest-priority one is reported: illegal first, then data storage, then alignment. `exc_status` is zero for any code other than 2.
- R10: An operation with no exception condition, including op 0 (no operation), yields `exc_code` = 0 and `exc_status` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Decoded operation code (0..16) |
| sr_imm | input | 4 | Immediate segment register number |
| rs_data | input | 32 | Data to write on a move-to |
| ea | input | 32 | Address operand / effective address |
| le_mode | input | 1 | Little-endian mode |
| xlate_en | input | 1 | Data translation enabled |
| ext_en | input | 1 | External-access enable |
| rd_data | output | 32 | Move-from read data |
| exc_code | output | 2 | 0 none, 1 illegal, 2 data storage, 3 alignment |
| exc_status | output | 32 | Fault status bits |

## Verification
The hardest case to reach is the overlap of conditions. An external-control access that is both disabled and misaligned under translation must report only the data storage fault. Its status bit must also not be mixed with alignment. The stimulus reaches this case by sweeping every op code against every combination of the three mode flags and three address low-bit patterns. The bench compares code and status against a behavioural model after each edge. Register addressing is covered in two steps: the bench writes each register through one addressing form and reads it back through the other.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
    localparam int DATA_W  = 32;
    localparam int NUM_SR  = 16;
    localparam int IDX_W   = $clog2(NUM_SR);
    localparam int OP_W    = 5;
    // big-endian status bit flagged for a disabled external access
    localparam int EXT_STATUS_BE = 11;
    localparam int EXT_STATUS_LE = DATA_W - 1 - EXT_STATUS_BE;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 5'd0,
        OP_SR_WR_DIR = 5'd1,
        OP_SR_WR_IND = 5'd2,
        OP_SR_RD_DIR = 5'd3,
        OP_SR_RD_IND = 5'd4,
        OP_EXT_RD    = 5'd5,
        OP_EXT_WR    = 5'd6,
        OP_LD_MULT   = 5'd7,
        OP_ST_MULT   = 5'd8,
        OP_STR_LD    = 5'd9,
        OP_STR_ST    = 5'd10,
        OP_LD_RSV    = 5'd11,
        OP_ST_COND   = 5'd12,
        OP_FP_LD     = 5'd13,
        OP_FP_ST     = 5'd14,
        OP_TLB_INV1  = 5'd15,
        OP_TLB_INVALL= 5'd16
    } op_t;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_ILL   = 2'd1,
        EXC_DSTOR = 2'd2,
        EXC_ALIGN = 2'd3
    } exc_t;

    typedef struct packed {
        exc_t              code;
        logic [DATA_W-1:0] status;
    } fault_t;

    function automatic logic is_ext(op_t o);
        return (o == OP_EXT_RD) || (o == OP_EXT_WR);
    endfunction

    function automatic logic is_mult(op_t o);
        return (o == OP_LD_MULT) || (o == OP_ST_MULT);
    endfunction

    function automatic logic is_string(op_t o);
        return (o == OP_STR_LD) || (o == OP_STR_ST);
    endfunction

    function automatic logic needs_word(op_t o);
        return is_mult(o) || is_ext(o) || (o == OP_LD_RSV) || (o == OP_ST_COND)
            || (o == OP_FP_LD) || (o == OP_FP_ST);
    endfunction
endpackage

// File: rtl/segchk_regfile.sv
module segchk_regfile
    import segchk_pkg::*;
#(
    parameter int N  = NUM_SR,
    parameter int W  = DATA_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_val
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_sr
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_val = regs[rd_idx];
endmodule

// File: rtl/segchk_fault.sv
module segchk_fault
    import segchk_pkg::*;
(
    input  op_t        op,
    input  logic [1:0] ea_lo,
    input  logic       le_mode,
    input  logic       xlate_en,
    input  logic       ext_en,
    output fault_t     fault
);
    logic ill_c, dstor_c, align_le_c, align_wd_c;

    always_comb begin
        ill_c      = (op == OP_TLB_INVALL);
        dstor_c    = is_ext(op) && !ext_en;
        align_le_c = le_mode && (is_mult(op) || is_string(op));
        align_wd_c = xlate_en && (ea_lo != 2'b00) && needs_word(op);
    end

    // priority: illegal, data storage, alignment
    always_comb begin
        fault.code   = EXC_NONE;
        fault.status = '0;
        if (ill_c) begin
            fault.code = EXC_ILL;
        end else if (dstor_c) begin
            fault.code = EXC_DSTOR;
            fault.status[EXT_STATUS_LE] = 1'b1;
        end else if (align_le_c || align_wd_c) begin
            fault.code = EXC_ALIGN;
        end
    end
endmodule

// File: rtl/segchk_unit.sv
module segchk_unit
    import segchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  sr_imm,
    input  logic [DATA_W-1:0] rs_data,
    input  logic [DATA_W-1:0] ea,
    input  logic              le_mode,
    input  logic              xlate_en,
    input  logic              ext_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        exc_code,
    output logic [DATA_W-1:0] exc_status
);
    op_t               op_e;
    logic              indirect, is_wr, is_rd;
    logic [IDX_W-1:0]  sel_idx;
    logic [DATA_W-1:0] sr_val;
    fault_t            fault_c, fault_q;

    always_comb begin
        op_e     = op_t'(op);
        indirect = (op_e == OP_SR_WR_IND) || (op_e == OP_SR_RD_IND);
        is_wr    = (op_e == OP_SR_WR_DIR) || (op_e == OP_SR_WR_IND);
        is_rd    = (op_e == OP_SR_RD_DIR) || (op_e == OP_SR_RD_IND);
        sel_idx  = indirect ? ea[DATA_W-1 -: IDX_W] : sr_imm;
    end

    segchk_regfile #(.N(NUM_SR), .W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (is_wr && (fault_c.code == EXC_NONE)),
        .wr_idx  (sel_idx),
        .wr_data (rs_data),
        .rd_idx  (sel_idx),
        .rd_val  (sr_val)
    );

    segchk_fault u_flt (
        .op       (op_e),
        .ea_lo    (ea[1:0]),
        .le_mode  (le_mode),
        .xlate_en (xlate_en),
        .ext_en   (ext_en),
        .fault    (fault_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q.code   <= EXC_NONE;
            fault_q.status <= '0;
        end else begin
            fault_q <= fault_c;
        end
    end

    assign rd_data    = is_rd ? sr_val : '0;
    assign exc_code   = fault_q.code;
    assign exc_status = fault_q.status;
endmodule

// File: rtl/segchk_sva.sv
module segchk_sva
    import segchk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op,
    input logic [IDX_W-1:0]  sr_imm,
    input logic [DATA_W-1:0] rs_data,
    input logic [DATA_W-1:0] ea,
    input logic              le_mode,
    input logic              xlate_en,
    input logic              ext_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        exc_code,
    input logic [DATA_W-1:0] exc_status
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (exc_code == 2'd0) && (exc_status == '0));

    // R5
    ext_dstor_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == 5'd5 || op == 5'd6) && !ext_en)
        |=> (exc_code == 2'd2) && (exc_status == (32'h1 << 20)));

    // R6
    le_align_chk: assert property (@(posedge clk) disable iff (rst)
        (le_mode && op >= 5'd7 && op <= 5'd10) |=> (exc_code == 2'd3));

    // R8
    tlb_all_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 5'd16) |=> (exc_code == 2'd1));

    // R9
    status_only_dstor_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_code != 2'd2) |-> (exc_status == '0));

    // R10
    nop_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 5'd0 || op == 5'd15) |=> (exc_code == 2'd0));

    // R4
    rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op != 5'd3 && op != 5'd4) |-> (rd_data == '0));
endmodule

bind segchk_unit segchk_sva u_sva (.*);

// File: tb/sim_segchk_unit.sv
`timescale 1ns/1ps
module sim_segchk_unit;
    import segchk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op = '0;
    logic [3:0]  sr_imm = '0;
    logic [31:0] rs_data = '0, ea = '0;
    logic        le_mode = 1'b0, xlate_en = 1'b0, ext_en = 1'b1;
    logic [31:0] rd_data, exc_status;
    logic [1:0]  exc_code;

    int checks = 0, fails = 0;
    logic [31:0] m_sr [16];

    always #2.5 clk = ~clk;

    segchk_unit u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural expectation of the fault code for one operation
    function automatic int exp_code(int o, logic [31:0] a, logic le, logic xl, logic ee);
        bit ext = (o == 5 || o == 6);
        bit word = (o >= 5 && o <= 8) || (o >= 11 && o <= 14);
        if (o == 16) return 1;
        if (ext && !ee) return 2;
        if (le && o >= 7 && o <= 10) return 3;
        if (xl && a[1:0] != 0 && word) return 3;
        return 0;
    endfunction

    // one cycle: drive at negedge, check rd_data, clock, check faults
    task automatic step(int o, logic [3:0] imm, logic [31:0] d, logic [31:0] a,
                        logic le, logic xl, logic ee, string req);
        int ec, idx;
        logic [31:0] exp_rd;
        @(negedge clk);
        op = 5'(o); sr_imm = imm; rs_data = d; ea = a;
        le_mode = le; xlate_en = xl; ext_en = ee;
        idx = (o == 2 || o == 4) ? int'(a[31:28]) : int'(imm);
        exp_rd = (o == 3 || o == 4) ? m_sr[idx] : 32'h0;
        ec = exp_code(o, a, le, xl, ee);
        #1 check({req, "/R4 rd_data"}, rd_data, exp_rd);
        @(posedge clk);
        if ((o == 1 || o == 2) && ec == 0) m_sr[idx] = d;
        #1;
        check({req, "/R9 code"}, 32'(exc_code), 32'(ec));
        check({req, "/R9 status"}, exc_status, (ec == 2) ? 32'h0010_0000 : 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_sr[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: exception outputs clear during reset
        check("R1 code", 32'(exc_code), 0);
        check("R1 status", exc_status, 0);
        @(negedge clk); rst = 1'b0;
        // R1: all registers read as zero after reset
        for (int i = 0; i < 16; i++) step(3, 4'(i), 0, 0, 0, 0, 1, "R1");
        // R2: direct writes, R3: indirect read-back
        for (int i = 0; i < 16; i++) step(1, 4'(i), 32'hA500_0000 + 32'(i * 7), 0, 0, 0, 1, "R2");
        for (int i = 0; i < 16; i++) step(4, 4'(15 - i), 0, {4'(i), 28'h123_4567}, 0, 0, 1, "R3");
        // R3: indirect writes, direct read-back
        for (int i = 0; i < 16; i++) step(2, 4'(i), 32'h5A5A_0000 ^ 32'(i << 4), {4'(15 - i), 28'h0}, 0, 1, 1, "R3");
        for (int i = 0; i < 16; i++) step(3, 4'(i), 0, 32'hFFFF_FFFF, 0, 0, 1, "R3");
        // R4: read in cycle right after write sees new value
        step(1, 4'd9, 32'hDEAD_BEEF, 0, 0, 0, 1, "R2");
        step(3, 4'd9, 0, 0, 0, 0, 1, "R4");
        // R5..R10: sweep all ops over flags and address low bits
        for (int o = 0; o <= 16; o++)
            for (int f = 0; f < 8; f++)
                for (int lo = 0; lo < 3; lo++) begin
                    logic [31:0] a = {4'(o), 26'h155_5555, 2'(lo)};
                    string tag = (o == 5 || o == 6) ? "R5" :
                                 (o >= 7 && o <= 10) ? "R6" :
                                 (o >= 11 && o <= 14) ? "R7" :
                                 (o >= 15) ? "R8" : "R10";
                    step(o, 4'(f + lo), 32'hC000_0000 + 32'(o * 64 + f * 4 + lo), a,
                         f[0], f[1], f[2], tag);
                end
        // R9: disabled and misaligned external access reports only data storage
        step(5, 0, 0, 32'h0000_0003, 1, 1, 0, "R9");
        step(6, 0, 0, 32'h0000_0001, 0, 1, 0, "R9");
        // R10: no-op after a fault clears outputs
        step(0, 0, 0, 0, 0, 0, 1, "R10");
        // final read of every register against the model
        for (int i = 0; i < 16; i++) step(3, 4'(i), 0, 0, 0, 0, 1, "R2");
        // R1: reset mid-run clears registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) m_sr[i] = '0;
        for (int i = 0; i < 16; i += 5) step(3, 4'(i), 0, 0, 0, 0, 1, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule